// File: doc/BRIEF.md
# Decrementer with Auto-Reload

This block is a down-counter paced by an external time-base strobe. Software loads the counter directly. On every cycle where the tick strobe is high, the counter drops by one. When the count reaches zero, a sticky expiry flag is raised. A second register holds a reload value. If the auto-reload control bit is set when the counter expires, the counter restarts from that value in the same tick. If the bit is clear, the counter parks at zero and stays quiet until software gives it a new nonzero count. The interrupt output is the expiry flag gated by an interrupt-enable control bit.

A small state machine drives the counter. It has two states:

- `ST_HALT`: the counter is parked at zero and ignores ticks. This is the reset state.
- `ST_RUN`: the counter counts down on ticks.

It has four transitions:

- **load**: a nonzero count write moves the machine from `ST_HALT` to `ST_RUN`.
- **expire-stop**: an expiry with auto-reload clear moves the machine from `ST_RUN` to `ST_HALT`.
- **expire-reload**: an expiry with auto-reload set keeps the machine in `ST_RUN` and loads the reload value.
- **count**: a tick with a count above one keeps the machine in `ST_RUN` and decrements.

A count write of zero leaves the machine in whatever state it is in.

The control word, the status word and the reload value are written through separate write strobes with 32-bit data.

Top module: `decrementer_ar`

## Requirements
- R1: After reset the count is 0, the expiry flag is 0, the interrupt output is 0, auto-reload is off and the state is `ST_HALT`.
- R2: The count changes only on a count write or on a cycle with `tick_i` high. In `ST_RUN`, a tick with a count above 1 lowers the count by exactly 1.
- R3: Expiry occurs on a tick in `ST_RUN` when the count is 1, which makes it reach zero. Expiry sets the flag (`flag_o`, status bit 27), visible after that clock edge.
- R4: The flag stays set until a status write with bit 27 equal to 1. A status write with bit 27 equal to 0 leaves the flag unchanged. An expiry in the same cycle as a clearing write leaves the flag set.
- R5: `irq_o` is high exactly when the flag is set and control bit 26 (interrupt enable) is 1.
- R6: If control bit 22 (auto-reload) is 1 at expiry, the count becomes the reload value at that same edge and the state stays `ST_RUN`.
- R7: If control bit 22 is 0 at expiry, the count holds at 0 and the state becomes `ST_HALT`. In `ST_HALT`, ticks cause no expiry. A count write of 0 in `ST_HALT` leaves the block halted, and no expiry follows. Only a nonzero count write restarts counting.
- R8: A count write takes priority over a decrement, reload or expiry in the same cycle. The written value appears on `count_o` after that edge.
- R9: A count write of 0 while in `ST_RUN` makes the next tick an expiry.
- R10: Expiry never changes the reload value, so successive reloads restore the same count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Time-base strobe, one decrement per high cycle |
| cnt_we_i | input | 1 | Count write strobe |
| cnt_wdata_i | input | 32 | Count write data |
| rld_we_i | input | 1 | Reload value write strobe |
| rld_wdata_i | input | 32 | Reload value write data |
| ctl_we_i | input | 1 | Control write strobe (bit 26 irq enable, bit 22 auto-reload) |
| ctl_wdata_i | input | 32 | Control write data |
| sts_we_i | input | 1 | Status write-one-to-clear strobe |
| sts_wdata_i | input | 32 | Status write data, bit 27 clears the flag |
| count_o | output | 32 | Current count |
| flag_o | output | 1 | Sticky expiry flag |
| irq_o | output | 1 | Gated interrupt output |

## Verification
Some properties are checked on every cycle:

- The count is stable without a tick or a write.
- `ST_HALT` always holds a zero count.
- A count write lands on the next cycle.
- An expiry raises the flag.
- An auto-reload expiry loads the reload value.
- The flag persists without a bit-27 clear.

The bench scenarios cover what needs a history:

- The halted block stays silent under ticks and under a zero write.
- A zero write in `ST_RUN` expires on the next tick.
- Set wins over a clear in the same cycle.
- Repeated reloads return to the same value.
- The interrupt follows the enable bit.

// File: rtl/dec_pkg.sv
package dec_pkg;
    localparam int DATA_W     = 32;
    localparam int STS_EXP_B  = 27;
    localparam int CTL_IE_B   = 26;
    localparam int CTL_AR_B   = 22;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } dec_state_e;
endpackage

// File: rtl/dec_ctl.sv
module dec_ctl
    import dec_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ctl_we_i,
    input  logic [31:0]  ctl_wdata_i,
    input  logic         rld_we_i,
    input  logic [W-1:0] rld_wdata_i,
    output logic         irq_en_o,
    output logic         auto_rld_o,
    output logic [W-1:0] rld_val_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en_o   <= 1'b0;
            auto_rld_o <= 1'b0;
            rld_val_o  <= '0;
        end else begin
            if (ctl_we_i) begin
                irq_en_o   <= ctl_wdata_i[CTL_IE_B];
                auto_rld_o <= ctl_wdata_i[CTL_AR_B];
            end
            if (rld_we_i) begin
                rld_val_o <= rld_wdata_i;
            end
        end
    end
endmodule

// File: rtl/dec_core.sv
module dec_core
    import dec_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    input  logic         auto_rld_i,
    input  logic [W-1:0] rld_val_i,
    output logic [W-1:0] count_o,
    output logic         expire_o
);
    localparam logic [W-1:0] ONE = W'(1);

    dec_state_e   state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        expire_o = 1'b0;
        if (we_i) begin
            cnt_d = wdata_i;
            if (wdata_i != '0) state_d = ST_RUN;
        end else begin
            unique case (state_q)
                ST_HALT: begin
                    cnt_d = '0;
                end
                ST_RUN: begin
                    if (tick_i) begin
                        if (cnt_q <= ONE) begin
                            expire_o = 1'b1;
                            if (auto_rld_i) begin
                                cnt_d = rld_val_i;
                            end else begin
                                cnt_d   = '0;
                                state_d = ST_HALT;
                            end
                        end else begin
                            cnt_d = cnt_q - ONE;
                        end
                    end
                end
                default: state_d = ST_HALT;
            endcase
        end
    end

    assign count_o = cnt_q;

    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !we_i) |=> $stable(cnt_q));
    a_r7_halt_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |-> (cnt_q == '0));
    a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (cnt_q == $past(wdata_i)));
endmodule

// File: rtl/dec_flag.sv
module dec_flag
    import dec_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        set_i,
    input  logic        clr_we_i,
    input  logic [31:0] clr_wdata_i,
    input  logic        irq_en_i,
    output logic        flag_o,
    output logic        irq_o
);
    logic flag_q;
    logic clr_hit;

    assign clr_hit = clr_we_i && clr_wdata_i[STS_EXP_B];

    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (set_i)   flag_q <= 1'b1;
        else if (clr_hit) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;
    assign irq_o  = flag_q & irq_en_i;

    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_hit) |=> flag_q);
endmodule

// File: rtl/decrementer_ar.sv
module decrementer_ar
    import dec_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         cnt_we_i,
    input  logic [W-1:0] cnt_wdata_i,
    input  logic         rld_we_i,
    input  logic [W-1:0] rld_wdata_i,
    input  logic         ctl_we_i,
    input  logic [31:0]  ctl_wdata_i,
    input  logic         sts_we_i,
    input  logic [31:0]  sts_wdata_i,
    output logic [W-1:0] count_o,
    output logic         flag_o,
    output logic         irq_o
);
    logic         irq_en;
    logic         auto_rld;
    logic [W-1:0] rld_val;
    logic         expire;

    dec_ctl #(.W(W)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .ctl_we_i(ctl_we_i), .ctl_wdata_i(ctl_wdata_i),
        .rld_we_i(rld_we_i), .rld_wdata_i(rld_wdata_i),
        .irq_en_o(irq_en), .auto_rld_o(auto_rld), .rld_val_o(rld_val)
    );

    dec_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .we_i(cnt_we_i), .wdata_i(cnt_wdata_i),
        .auto_rld_i(auto_rld), .rld_val_i(rld_val),
        .count_o(count_o), .expire_o(expire)
    );

    dec_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set_i(expire),
        .clr_we_i(sts_we_i), .clr_wdata_i(sts_wdata_i),
        .irq_en_i(irq_en), .flag_o(flag_o), .irq_o(irq_o)
    );

    a_r3_expiry_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag_o);
    a_r6_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && auto_rld) |=> (count_o == $past(rld_val)));
endmodule

// File: tb/decrementer_ar_bench.sv
module decrementer_ar_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        cnt_we_i = 1'b0;
    logic [31:0] cnt_wdata_i = '0;
    logic        rld_we_i = 1'b0;
    logic [31:0] rld_wdata_i = '0;
    logic        ctl_we_i = 1'b0;
    logic [31:0] ctl_wdata_i = '0;
    logic        sts_we_i = 1'b0;
    logic [31:0] sts_wdata_i = '0;
    logic [31:0] count_o;
    logic        flag_o;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [31:0] B_EXP = 32'h1 << 27;
    localparam logic [31:0] B_IE  = 32'h1 << 26;
    localparam logic [31:0] B_AR  = 32'h1 << 22;

    always #5 clk = ~clk;

    decrementer_ar u_decrementer_ar (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic t);
        tick_i = t;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic wr_cnt(input logic [31:0] v);
        cnt_we_i = 1'b1; cnt_wdata_i = v;
        @(negedge clk);
        cnt_we_i = 1'b0;
    endtask

    task automatic wr_ctl(input logic [31:0] v);
        ctl_we_i = 1'b1; ctl_wdata_i = v;
        @(negedge clk);
        ctl_we_i = 1'b0;
    endtask

    task automatic wr_rld(input logic [31:0] v);
        rld_we_i = 1'b1; rld_wdata_i = v;
        @(negedge clk);
        rld_we_i = 1'b0;
    endtask

    task automatic wr_sts(input logic [31:0] v);
        sts_we_i = 1'b1; sts_wdata_i = v;
        @(negedge clk);
        sts_we_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 count", count_o, 0);
        chk("R1 flag", {31'b0, flag_o}, 0);
        chk("R1 irq", {31'b0, irq_o}, 0);
        cyc(1'b1);
        chk("R1 halted at reset", count_o, 0);
        chk("R1 no expiry at reset", {31'b0, flag_o}, 0);
    endtask

    task automatic t_decrement();
        wr_cnt(5);
        chk("R8 write", count_o, 5);
        for (int i = 0; i < 3; i++) cyc(1'b0);
        chk("R2 no tick hold", count_o, 5);
        cyc(1'b1);
        chk("R2 decrement", count_o, 4);
        cyc(1'b1); cyc(1'b1);
        chk("R2 decrement x2", count_o, 2);
    endtask

    task automatic t_expire_stop();
        cyc(1'b1);
        chk("R3 count at 1", count_o, 1);
        chk("R3 no early flag", {31'b0, flag_o}, 0);
        cyc(1'b1);
        chk("R3 reach zero", count_o, 0);
        chk("R3 flag set", {31'b0, flag_o}, 1);
        for (int i = 0; i < 3; i++) cyc(1'b1);
        chk("R7 hold zero", count_o, 0);
        wr_sts(B_EXP);
        chk("R4 cleared", {31'b0, flag_o}, 0);
        for (int i = 0; i < 3; i++) cyc(1'b1);
        chk("R7 no re-expiry", {31'b0, flag_o}, 0);
        wr_cnt(0);
        cyc(1'b1); cyc(1'b1);
        chk("R7 zero write in halt silent", {31'b0, flag_o}, 0);
        wr_cnt(2);
        cyc(1'b1); cyc(1'b1);
        chk("R7 nonzero write restarts", {31'b0, flag_o}, 1);
    endtask

    task automatic t_w1c();
        wr_sts(B_IE);
        chk("R4 other bit ignored", {31'b0, flag_o}, 1);
        wr_sts(B_EXP);
        chk("R4 bit27 clears", {31'b0, flag_o}, 0);
        wr_cnt(1);
        tick_i = 1'b1; sts_we_i = 1'b1; sts_wdata_i = B_EXP;
        @(negedge clk);
        tick_i = 1'b0; sts_we_i = 1'b0;
        chk("R4 set wins over clear", {31'b0, flag_o}, 1);
    endtask

    task automatic t_irq();
        chk("R5 irq off when disabled", {31'b0, irq_o}, 0);
        wr_ctl(B_IE);
        chk("R5 irq on", {31'b0, irq_o}, 1);
        wr_sts(B_EXP);
        chk("R5 irq drops with flag", {31'b0, irq_o}, 0);
    endtask

    task automatic t_autoreload();
        wr_ctl(B_IE | B_AR);
        wr_rld(3);
        wr_cnt(2);
        cyc(1'b1);
        chk("R2 count 1", count_o, 1);
        cyc(1'b1);
        chk("R6 reloaded", count_o, 3);
        chk("R3 flag on reload", {31'b0, flag_o}, 1);
        chk("R5 irq on reload", {31'b0, irq_o}, 1);
        wr_sts(B_EXP);
        cyc(1'b1); cyc(1'b1);
        chk("R6 keeps running", count_o, 1);
        cyc(1'b1);
        chk("R10 same reload", count_o, 3);
        chk("R10 flag again", {31'b0, flag_o}, 1);
        wr_sts(B_EXP);
    endtask

    task automatic t_priority();
        wr_ctl(0);
        wr_cnt(1);
        tick_i = 1'b1; cnt_we_i = 1'b1; cnt_wdata_i = 7;
        @(negedge clk);
        tick_i = 1'b0; cnt_we_i = 1'b0;
        chk("R8 write beats tick", count_o, 7);
        chk("R8 no expiry", {31'b0, flag_o}, 0);
    endtask

    task automatic t_zero_write();
        wr_cnt(4);
        wr_cnt(0);
        cyc(1'b0);
        chk("R9 no flag before tick", {31'b0, flag_o}, 0);
        cyc(1'b1);
        chk("R9 expiry on next tick", {31'b0, flag_o}, 1);
        chk("R9 count zero", count_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_decrement();
        t_expire_stop();
        t_w1c();
        t_irq();
        t_autoreload();
        t_priority();
        t_zero_write();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule